// File: doc/BRIEF.md
# Protection Region Register Bank

This block is the software-visible configuration store of a memory protection unit. It holds a global control word and, for a parameterised number of regions (up to 16), a base address and a size/access attribute pair. Software reaches the per-region registers indirectly: a region-select register chooses which region the base and attribute windows address. A base write can also carry its own region index and move the select in the same access.

Every stored field is masked to its legal bits, and accesses that target a region that does not exist are dropped. The whole region table and the control bits are driven out in parallel to a downstream permission checker. A single-cycle invalidate strobe tells cached permission results to flush whenever the protection setup changes. An error strobe marks configuration mistakes.

The bus is a simple word-wide read/write port with a 12-bit byte offset. Reads return data one cycle after the read strobe.

Top module: `mpu_regbank`

## Requirements
- R1: After reset every register reads 0 (apart from the read-only type word), the control and region-table outputs are 0, and `inval_o`/`err_o` are low.
- R2: Offset 0xD90 is a read-only type word returning NUM_REGIONS in bits [15:8] and 0 elsewhere; writes to it change nothing and raise no strobe.
- R3: Offset 0xD94 is the control word; only bit 0 (enable), bit 1 (fault-handler enable) and bit 2 (privileged default map) are stored, and they drive `ctrl_enable_o`, `ctrl_fault_en_o` and `ctrl_priv_default_o`; a read returns them in the same positions.
- R4: A control write with bit 1 set and bit 0 clear is stored as written and also pulses `err_o` for one cycle.
- R5: Offset 0xD98 is the region select; a write with a value below NUM_REGIONS is stored and reads back in bits [3:0]; a write at or above NUM_REGIONS is ignored and pulses `err_o`.
- R6: A base write with bit 4 set targets the region in bits [3:0] and also copies that index into the region select; with bit 4 clear it targets the selected region. A base write whose target is out of range is dropped, leaving table and select unchanged, and pulses `err_o`.
- R7: A base write stores bits [31:5] of the data; a base read returns the stored address in [31:5], 0 in bit 4 and the region select in [3:0].
- R8: An attribute write stores data[15:0] AND 0xFF3F as the size field and data[31:16] AND 0x173F as the access field of the selected region; an attribute read returns access in [31:16] and size in [15:0].
- R9: The base register is also reached at 0xDA4, 0xDAC and 0xDB4, and the attribute register at 0xDA8, 0xDB0 and 0xDB8, with identical behaviour.
- R10: `inval_o` is high for exactly one cycle after each accepted write to control, base or attribute, and stays low for region-select, type, unmapped and dropped writes.
- R11: Reads of any other offset, including unaligned ones, return 0, and writes to them change nothing.
- R12: `rdata_o` is loaded on the clock edge where `rd_en_i` is high, reflecting the state before that edge, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 12 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the read strobe |
| ctrl_enable_o | output | 1 | Protection enable |
| ctrl_fault_en_o | output | 1 | Protection active in fault handlers |
| ctrl_priv_default_o | output | 1 | Privileged default map enable |
| region_base_o | output | NUM_REGIONS*27 | Base address bits [31:5] per region |
| region_size_o | output | NUM_REGIONS*16 | Masked size/enable field per region |
| region_access_o | output | NUM_REGIONS*16 | Masked access field per region |
| inval_o | output | 1 | One-cycle flush strobe after a configuration change |
| err_o | output | 1 | One-cycle configuration-error strobe |

## Verification
The hardest situation to reach is a base write whose own region index is out of range. It must be dropped while leaving the region select untouched, and a read through the same window right afterwards must still show the old select and table entry. The bench first moves the select to a known in-range region. It then issues a VALID base write naming region 15 and reads the base window back. The checks confirm that the select, the stored entry and the absent invalidate strobe all show that nothing happened, and that the error strobe fired.

// File: rtl/mpu_regbank_pkg.sv
package mpu_regbank_pkg;

    localparam int MAX_REGIONS = 16;
    localparam int ADDR_W      = 12;
    localparam int DATA_W      = 32;
    localparam int IDX_W       = 4;
    localparam int BASE_LSB    = 5;
    localparam int BASE_W      = DATA_W - BASE_LSB;
    localparam int HALF_W      = DATA_W / 2;
    localparam int VALID_BIT   = 4;

    localparam logic [ADDR_W-1:0] OFF_TYPE   = 12'hD90;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 12'hD94;
    localparam logic [ADDR_W-1:0] OFF_SELECT = 12'hD98;
    localparam logic [ADDR_W-1:0] OFF_PAIR_LO = 12'hD9C;
    localparam logic [ADDR_W-1:0] OFF_PAIR_HI = 12'hDB8;

    localparam logic [HALF_W-1:0] SIZE_KEEP   = 16'hFF3F;
    localparam logic [HALF_W-1:0] ACCESS_KEEP = 16'h173F;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TYPE,
        SEL_CTRL,
        SEL_SELECT,
        SEL_BASE,
        SEL_ATTR
    } reg_sel_e;

    typedef struct packed {
        logic priv_default;
        logic fault_en;
        logic enable;
    } ctrl_t;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [HALF_W-1:0] size;
        logic [HALF_W-1:0] access;
    } region_t;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] rel;
        reg_sel_e s;
        rel = a - OFF_PAIR_LO;
        s = SEL_NONE;
        if (a[1:0] == 2'b00) begin
            if (a == OFF_TYPE)        s = SEL_TYPE;
            else if (a == OFF_CTRL)   s = SEL_CTRL;
            else if (a == OFF_SELECT) s = SEL_SELECT;
            else if (a >= OFF_PAIR_LO && a <= OFF_PAIR_HI)
                s = rel[2] ? SEL_ATTR : SEL_BASE;
        end
        return s;
    endfunction

    function automatic logic [HALF_W-1:0] mask_size(input logic [HALF_W-1:0] v);
        return v & SIZE_KEEP;
    endfunction

    function automatic logic [HALF_W-1:0] mask_access(input logic [HALF_W-1:0] v);
        return v & ACCESS_KEEP;
    endfunction

endpackage

// File: rtl/mpu_addr_decode.sv
module mpu_addr_decode
    import mpu_regbank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o
);
    always_comb begin
        sel_o = decode_offset(addr_i);
    end
endmodule

// File: rtl/mpu_ctrl_regs.sv
module mpu_ctrl_regs
    import mpu_regbank_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  reg_sel_e          sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output ctrl_t             ctrl_o,
    output logic [IDX_W-1:0]  select_o,
    output logic [IDX_W-1:0]  target_o,
    output logic              target_ok_o,
    output logic              select_ok_o,
    output logic              accept_o,
    output logic              err_event_o
);
    localparam logic [DATA_W-1:0] COUNT_W = DATA_W'(NUM_REGIONS);
    localparam logic [IDX_W:0]    COUNT_I = (IDX_W+1)'(NUM_REGIONS);

    ctrl_t            ctrl_q;
    logic [IDX_W-1:0] select_q;
    logic             retarget;
    logic             sel_write_ok;
    logic             ctrl_suspicious;

    always_comb begin
        retarget        = wdata_i[VALID_BIT];
        target_o        = retarget ? wdata_i[IDX_W-1:0] : select_q;
        target_ok_o     = {1'b0, target_o} < COUNT_I;
        select_ok_o     = {1'b0, select_q} < COUNT_I;
        sel_write_ok    = wdata_i < COUNT_W;
        ctrl_suspicious = wdata_i[1] & ~wdata_i[0];

        accept_o = wr_en_i & ((sel_i == SEL_CTRL)
                            | ((sel_i == SEL_BASE) & target_ok_o)
                            | ((sel_i == SEL_ATTR) & select_ok_o));

        err_event_o = wr_en_i & (((sel_i == SEL_CTRL) & ctrl_suspicious)
                               | ((sel_i == SEL_SELECT) & ~sel_write_ok)
                               | ((sel_i == SEL_BASE) & ~target_ok_o));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            select_q <= '0;
        end else if (wr_en_i) begin
            if (sel_i == SEL_CTRL) begin
                ctrl_q.enable       <= wdata_i[0];
                ctrl_q.fault_en     <= wdata_i[1];
                ctrl_q.priv_default <= wdata_i[2];
            end
            if (sel_i == SEL_SELECT && sel_write_ok)
                select_q <= wdata_i[IDX_W-1:0];
            if (sel_i == SEL_BASE && retarget && target_ok_o)
                select_q <= wdata_i[IDX_W-1:0];
        end
    end

    assign ctrl_o   = ctrl_q;
    assign select_o = select_q;
endmodule

// File: rtl/mpu_region_store.sv
module mpu_region_store
    import mpu_regbank_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we_base_i,
    input  logic                      we_attr_i,
    input  logic [IDX_W-1:0]          base_idx_i,
    input  logic [IDX_W-1:0]          attr_idx_i,
    input  logic [DATA_W-1:0]         wdata_i,
    output region_t [NUM_REGIONS-1:0] table_o
);
    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(r);
        region_t entry_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q <= '0;
            end else begin
                if (we_base_i && base_idx_i == MY_IDX)
                    entry_q.base <= wdata_i[DATA_W-1:BASE_LSB];
                if (we_attr_i && attr_idx_i == MY_IDX) begin
                    entry_q.size   <= mask_size(wdata_i[HALF_W-1:0]);
                    entry_q.access <= mask_access(wdata_i[DATA_W-1:HALF_W]);
                end
            end
        end

        assign table_o[r] = entry_q;
    end
endmodule

// File: rtl/mpu_regbank.sv
module mpu_regbank
    import mpu_regbank_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en_i,
    input  logic                          rd_en_i,
    input  logic [11:0]                   addr_i,
    input  logic [31:0]                   wdata_i,
    output logic [31:0]                   rdata_o,
    output logic                          ctrl_enable_o,
    output logic                          ctrl_fault_en_o,
    output logic                          ctrl_priv_default_o,
    output logic [NUM_REGIONS*27-1:0]     region_base_o,
    output logic [NUM_REGIONS*16-1:0]     region_size_o,
    output logic [NUM_REGIONS*16-1:0]     region_access_o,
    output logic                          inval_o,
    output logic                          err_o
);
    localparam logic [DATA_W-1:0] TYPE_WORD = DATA_W'(NUM_REGIONS) << 8;

    reg_sel_e                  sel;
    ctrl_t                     ctrl;
    logic [IDX_W-1:0]          select_q;
    logic [IDX_W-1:0]          target;
    logic                      target_ok;
    logic                      select_ok;
    logic                      accept;
    logic                      err_event;
    region_t [NUM_REGIONS-1:0] rtable;
    region_t                   cur_entry;
    logic [DATA_W-1:0]         rd_mux;
    logic [DATA_W-1:0]         rdata_q;
    logic                      inval_q;
    logic                      err_q;

    mpu_addr_decode u_decode (
        .addr_i (addr_i),
        .sel_o  (sel)
    );

    mpu_ctrl_regs #(.NUM_REGIONS(NUM_REGIONS)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .wr_en_i     (wr_en_i),
        .sel_i       (sel),
        .wdata_i     (wdata_i),
        .ctrl_o      (ctrl),
        .select_o    (select_q),
        .target_o    (target),
        .target_ok_o (target_ok),
        .select_ok_o (select_ok),
        .accept_o    (accept),
        .err_event_o (err_event)
    );

    mpu_region_store #(.NUM_REGIONS(NUM_REGIONS)) u_store (
        .clk        (clk),
        .rst        (rst),
        .we_base_i  (wr_en_i && sel == SEL_BASE && target_ok),
        .we_attr_i  (wr_en_i && sel == SEL_ATTR && select_ok),
        .base_idx_i (target),
        .attr_idx_i (select_q),
        .wdata_i    (wdata_i),
        .table_o    (rtable)
    );

    always_comb begin
        cur_entry = select_ok ? rtable[select_q] : '0;
        rd_mux    = '0;
        unique case (sel)
            SEL_TYPE:   rd_mux = TYPE_WORD;
            SEL_CTRL:   rd_mux = DATA_W'(ctrl);
            SEL_SELECT: rd_mux = DATA_W'(select_q);
            SEL_BASE:   rd_mux = select_ok
                               ? {cur_entry.base, 1'b0, select_q} : '0;
            SEL_ATTR:   rd_mux = select_ok
                               ? {cur_entry.access, cur_entry.size} : '0;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            inval_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (rd_en_i) rdata_q <= rd_mux;
            inval_q <= accept;
            err_q   <= err_event;
        end
    end

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_flat
        assign region_base_o[r*BASE_W +: BASE_W]   = rtable[r].base;
        assign region_size_o[r*HALF_W +: HALF_W]   = rtable[r].size;
        assign region_access_o[r*HALF_W +: HALF_W] = rtable[r].access;
    end

    assign rdata_o             = rdata_q;
    assign ctrl_enable_o       = ctrl.enable;
    assign ctrl_fault_en_o     = ctrl.fault_en;
    assign ctrl_priv_default_o = ctrl.priv_default;
    assign inval_o             = inval_q;
    assign err_o               = err_q;
endmodule

// File: rtl/mpu_regbank_checker.sv
module mpu_regbank_checker
    import mpu_regbank_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      wr_en_i,
    input logic [11:0]               addr_i,
    input logic [31:0]               wdata_i,
    input logic                      ctrl_enable_o,
    input logic                      ctrl_fault_en_o,
    input logic                      ctrl_priv_default_o,
    input logic [NUM_REGIONS*16-1:0] region_size_o,
    input logic [NUM_REGIONS*16-1:0] region_access_o,
    input logic                      inval_o,
    input logic                      err_o,
    input logic [3:0]                select_q
);
    localparam logic [31:0] COUNT = 32'(NUM_REGIONS);

    // R5: the region select never holds a nonexistent region
    assert_select_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        {28'd0, select_q} < COUNT);

    // R5: an out-of-range select write leaves the select alone and flags it
    assert_bad_select_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == 12'hD98 && wdata_i >= COUNT)
        |=> (err_o && $stable(select_q)));

    // R3: control write lands in the three control outputs
    assert_ctrl_capture_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == 12'hD94)
        |=> (ctrl_enable_o == $past(wdata_i[0]) &&
             ctrl_fault_en_o == $past(wdata_i[1]) &&
             ctrl_priv_default_o == $past(wdata_i[2])));

    // R10: the invalidate strobe always follows a write
    assert_inval_cause_R10: assert property (@(posedge clk) disable iff (rst)
        inval_o |-> $past(wr_en_i));

    // R2: writing the type word raises no strobe
    assert_type_ro_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == 12'hD90) |=> (!inval_o && !err_o));

    // R8: stored fields only ever carry their legal bits
    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_mask
        assert_attr_mask_R8: assert property (@(posedge clk) disable iff (rst)
            ((region_size_o[r*16 +: 16] & ~SIZE_KEEP) == 16'd0) &&
            ((region_access_o[r*16 +: 16] & ~ACCESS_KEEP) == 16'd0));
    end
endmodule

bind mpu_regbank mpu_regbank_checker #(.NUM_REGIONS(NUM_REGIONS)) u_checker (
    .clk                 (clk),
    .rst                 (rst),
    .wr_en_i             (wr_en_i),
    .addr_i              (addr_i),
    .wdata_i             (wdata_i),
    .ctrl_enable_o       (ctrl_enable_o),
    .ctrl_fault_en_o     (ctrl_fault_en_o),
    .ctrl_priv_default_o (ctrl_priv_default_o),
    .region_size_o       (region_size_o),
    .region_access_o     (region_access_o),
    .inval_o             (inval_o),
    .err_o               (err_o),
    .select_q            (select_q)
);

// File: tb/mpu_regbank_test.sv
module mpu_regbank_test;
    localparam int N = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en_i = 1'b0;
    logic            rd_en_i = 1'b0;
    logic [11:0]     addr_i = '0;
    logic [31:0]     wdata_i = '0;
    logic [31:0]     rdata_o;
    logic            ctrl_enable_o, ctrl_fault_en_o, ctrl_priv_default_o;
    logic [N*27-1:0] region_base_o;
    logic [N*16-1:0] region_size_o;
    logic [N*16-1:0] region_access_o;
    logic            inval_o, err_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    mpu_regbank #(.NUM_REGIONS(N)) uut (
        .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .ctrl_enable_o(ctrl_enable_o), .ctrl_fault_en_o(ctrl_fault_en_o),
        .ctrl_priv_default_o(ctrl_priv_default_o),
        .region_base_o(region_base_o), .region_size_o(region_size_o),
        .region_access_o(region_access_o), .inval_o(inval_o), .err_o(err_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // one write; returns at the negedge after the capturing edge
    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr_i = a; rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
        d = rdata_o;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 ctrl outputs", {29'd0, ctrl_priv_default_o, ctrl_fault_en_o, ctrl_enable_o}, 0);
        check("R1 strobes", {30'd0, inval_o, err_o}, 0);
        check("R1 region size out", region_size_o[31:0], 0);
        bus_read(12'hD94, d); check("R1 ctrl read", d, 0);
        bus_read(12'hD98, d); check("R1 select read", d, 0);
        bus_read(12'hD9C, d); check("R1 base read", d, 0);
        bus_read(12'hDA0, d); check("R1 attr read", d, 0);
    endtask

    task automatic t_type();
        logic [31:0] d;
        bus_read(12'hD90, d); check("R2 type read", d, 32'h0000_0800);
        bus_write(12'hD90, 32'hFFFF_FFFF);
        check("R2 type write no strobe", {30'd0, inval_o, err_o}, 0);
        bus_read(12'hD90, d); check("R2 type after write", d, 32'h0000_0800);
        bus_read(12'hD94, d); check("R2 ctrl untouched", d, 0);
    endtask

    task automatic t_ctrl();
        logic [31:0] d;
        bus_write(12'hD94, 32'hFFFF_FFFF);
        check("R10 ctrl inval", {31'd0, inval_o}, 1);
        check("R3 ctrl no err", {31'd0, err_o}, 0);
        check("R3 ctrl outputs", {29'd0, ctrl_priv_default_o, ctrl_fault_en_o, ctrl_enable_o}, 7);
        bus_read(12'hD94, d); check("R3 ctrl read masked", d, 7);
        check("R10 inval one cycle", {31'd0, inval_o}, 0);
        bus_write(12'hD94, 32'h0000_0002);
        check("R4 fault without enable err", {31'd0, err_o}, 1);
        bus_read(12'hD94, d); check("R4 still stored", d, 2);
        bus_write(12'hD94, 32'h0000_0000);
    endtask

    task automatic t_select();
        logic [31:0] d;
        bus_write(12'hD98, 32'd5);
        check("R10 select write no inval", {31'd0, inval_o}, 0);
        bus_read(12'hD98, d); check("R5 select stored", d, 5);
        bus_write(12'hD98, 32'd8);
        check("R5 at count err", {31'd0, err_o}, 1);
        bus_read(12'hD98, d); check("R5 at count ignored", d, 5);
        bus_write(12'hD98, 32'h0000_0013);
        check("R5 high bits err", {31'd0, err_o}, 1);
        bus_read(12'hD98, d); check("R5 high bits ignored", d, 5);
    endtask

    task automatic t_base();
        logic [31:0] d;
        bus_write(12'hD9C, 32'h1234_5662);
        check("R10 base inval", {31'd0, inval_o}, 1);
        check("R7 base table", {5'd0, region_base_o[5*27 +: 27]}, 32'h1234_5662 >> 5);
        bus_read(12'hD9C, d); check("R7 base read", d, 32'h1234_5665);
        bus_write(12'hD9C, 32'h2000_00FF);
        check("R6 bad target err", {31'd0, err_o}, 1);
        check("R10 dropped no inval", {31'd0, inval_o}, 0);
        bus_read(12'hD9C, d); check("R6 dropped keeps select", d, 32'h1234_5665);
        bus_write(12'hD9C, 32'hABCD_E013);
        bus_read(12'hD98, d); check("R6 valid moves select", d, 3);
        bus_read(12'hD9C, d); check("R7 base low bits cleared", d, 32'hABCD_E003);
        check("R6 old region intact", {5'd0, region_base_o[5*27 +: 27]}, 32'h1234_5662 >> 5);
    endtask

    task automatic t_attr();
        logic [31:0] d;
        bus_write(12'hDA0, 32'hFFFF_FFFF);
        check("R10 attr inval", {31'd0, inval_o}, 1);
        check("R8 size out", {16'd0, region_size_o[3*16 +: 16]}, 32'h0000_FF3F);
        check("R8 access out", {16'd0, region_access_o[3*16 +: 16]}, 32'h0000_173F);
        bus_read(12'hDA0, d); check("R8 attr read", d, 32'h173F_FF3F);
    endtask

    task automatic t_alias();
        logic [31:0] d;
        bus_write(12'hDB4, 32'h8000_0011);
        bus_read(12'hDA4, d); check("R9 base alias", d, 32'h8000_0001);
        bus_write(12'hDA8, 32'h0001_0002);
        bus_read(12'hDB8, d); check("R9 attr alias", d, 32'h0001_0002);
        bus_read(12'hDAC, d); check("R9 base alias2", d, 32'h8000_0001);
        check("R9 size region1", {16'd0, region_size_o[1*16 +: 16]}, 2);
        bus_write(12'hDB0, 32'h0000_00C0);
        bus_read(12'hDA0, d); check("R8 size mask bits", d, 32'h0000_0000);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bus_read(12'hD8C, d); check("R11 below read", d, 0);
        bus_write(12'hDBC, 32'hFFFF_FFFF);
        check("R11 unmapped write no strobe", {30'd0, inval_o, err_o}, 0);
        bus_read(12'hDBC, d); check("R11 above read", d, 0);
        bus_read(12'hD95, d); check("R11 unaligned read", d, 0);
        bus_write(12'hD96, 32'h0000_0007);
        check("R11 unaligned write ignored", {31'd0, ctrl_enable_o}, 0);
    endtask

    task automatic t_read_timing();
        @(negedge clk);
        addr_i = 12'hD98; wdata_i = 32'd6; wr_en_i = 1'b1; rd_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; rd_en_i = 1'b0;
        check("R12 read sees old value", rdata_o, 1);
        addr_i = 12'hD90;
        @(negedge clk);
        check("R12 rdata holds", rdata_o, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_type();
        t_ctrl();
        t_select();
        t_base();
        t_attr();
        t_alias();
        t_unmapped();
        t_read_timing();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule